// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns each bus cycle on a 24-bit address bus into one active-low chip select for an external memory device. It also produces the matching data-acknowledge strobe. There are four channels. Each channel has a base word and an option word, which software loads over a small write-only register port. The base word places an address window and gives a function-code value and a read/write qualifier. The option word gives the window size as a mask over address bits A23..A13, and it turns the function-code and read/write comparisons on or off. It also sets how many clock cycles pass before the acknowledge.

Channel 0 comes out of reset enabled, so a processor can fetch its first instructions from a boot memory before any register has been written. Boot software then widens or moves the windows and opens the other channels, for example to move working memory down to address zero. The decision for a bus cycle is taken once, on the first clock edge where address strobe is seen low. It then holds until the strobe is released.

Top module: `cs_decoder`

## Requirements
- R1: After reset, channel 0 is enabled with base 0, an 8 Kbyte window, function code 110b with function-code comparison on, read/write comparison off, and 6 wait states. Channels 1 to 3 are disabled. While address strobe is high, all chip selects and the acknowledge are high.
- R2: With function-code comparison on (option bit 4 = 1), a channel matches only when the function code equals base bits [4:2]. With that bit cleared, any function code matches.
- R3: A channel matches when it is enabled (base bit 0 = 1) and address bits A23..A13 agree with base bits [15:5] in every position where option bits [15:5] are 1. A mask of 11111111111b gives an 8 Kbyte window, and 11111100000b gives a 256 Kbyte window.
- R4: The acknowledge goes low W+1 clock edges after the edge that first sees address strobe low, where W is the selected channel's option bits [2:0] (0 to 7). The chip select goes low after the first of those edges.
- R5: When several enabled channels match, only the lowest-numbered one asserts its chip select.
- R6: A bus cycle to the configuration word at byte address 0x0000F2 or 0x0000F3 asserts no chip select, even where a channel window covers it.
- R7: With read/write comparison on (option bit 3 = 1), a channel matches only when the read/write line (1 = read) equals base bit 1. With it off, both directions match.
- R8: A bus cycle that no channel matches drives no chip select and never pulls the acknowledge low.
- R9: Chip selects stay low for as long as address strobe is low. They and the acknowledge return high on the first clock edge that sees the strobe high.
- R10: A register write made during a bus cycle leaves that cycle's chip select and acknowledge unchanged. It governs from the next bus cycle on.
- R11: The register port addresses channel `reg_ch`. It writes the base word when `reg_opt` = 0 and the option word when `reg_opt` = 1, with layouts {base[10:0], fc[2:0], rwq, en} and {mask[10:0], cfc, rwc, wait[2:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel addressed by the write |
| reg_opt | input | 1 | 0 = base word, 1 = option word |
| reg_wdata | input | 16 | Write data |
| addr | input | 24 | Bus address |
| fc | input | 3 | Bus function code |
| rw | input | 1 | 1 = read, 0 = write |
| as_n | input | 1 | Address strobe, active low |
| cs_n | output | 4 | Chip selects, active low, one per channel |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
The bench sweeps every value of A23..A13 over a set of overlapping windows. It checks each result against an arithmetic model of the matching rules. A wrong mask polarity or a reversed priority would select the wrong device across whole regions of the sweep. Focused cycles cover the following cases:
- Edges of the 8 Kbyte and 256 Kbyte windows, where an off-by-one mask bit would leak a select just outside the window.
- Function-code and direction filters, which a design that ignores a compare bit would let through.
- The reserved configuration word, which a careless decoder would map to memory.
- Wait counts of 0, 1, 2, 3 and 6, where an extra or missing register shows up as a shifted acknowledge.
- Disabling channel 0 in the middle of a cycle, which must not glitch the select that is already active.

// File: rtl/cs_pkg.sv
package cs_pkg;
    parameter int ADDR_W = 24;
    parameter int MASK_W = 11;
    parameter int FC_W   = 3;
    parameter int WAIT_W = 3;
    parameter int REG_W  = 16;
    localparam int LOW_BIT = ADDR_W - MASK_W;

    typedef struct packed {
        logic [MASK_W-1:0] base;
        logic [FC_W-1:0]   fc;
        logic              rwq;
        logic              en;
    } base_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              cfc;
        logic              rwc;
        logic [WAIT_W-1:0] ws;
    } opt_t;

    localparam base_t BOOT_BASE = '{base: '0, fc: 3'b110, rwq: 1'b0, en: 1'b1};
    localparam opt_t  BOOT_OPT  = '{mask: '1, cfc: 1'b1, rwc: 1'b0, ws: 3'd6};
    localparam base_t OFF_BASE  = '{base: '0, fc: '0, rwq: 1'b0, en: 1'b0};
    localparam opt_t  OFF_OPT   = '{mask: '0, cfc: 1'b0, rwc: 1'b0, ws: '0};

    // word address of the fixed configuration register (byte 0x0000F2)
    localparam logic [ADDR_W-1:0] RSV_ADDR = 24'h0000F2;

    function automatic logic chan_hit(base_t b, opt_t o, logic [ADDR_W-1:0] a,
                                      logic [FC_W-1:0] f, logic rd);
        logic win_ok, fc_ok, rw_ok;
        win_ok = (((a[ADDR_W-1:LOW_BIT] ^ b.base) & o.mask) == '0);
        fc_ok  = !o.cfc || (f == b.fc);
        rw_ok  = !o.rwc || (rd == b.rwq);
        return b.en && win_ok && fc_ok && rw_ok;
    endfunction

    function automatic logic is_reserved(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:1] == RSV_ADDR[ADDR_W-1:1];
    endfunction
endpackage

// File: rtl/cs_regs.sv
module cs_regs
    import cs_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CH_W-1:0]  ch,
    input  logic             sel_opt,
    input  logic [REG_W-1:0] wdata,
    output base_t            base_q [NUM_CH],
    output opt_t             opt_q  [NUM_CH]
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam base_t RST_B = (i == 0) ? BOOT_BASE : OFF_BASE;
        localparam opt_t  RST_O = (i == 0) ? BOOT_OPT  : OFF_OPT;
        logic hit_ch;
        assign hit_ch = we && (ch == CH_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[i] <= RST_B;
                opt_q[i]  <= RST_O;
            end else if (hit_ch) begin
                if (sel_opt) opt_q[i]  <= opt_t'(wdata);
                else         base_q[i] <= base_t'(wdata);
            end
        end
    end
endmodule

// File: rtl/cs_match.sv
module cs_match
    import cs_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  base_t              base_q [NUM_CH],
    input  opt_t               opt_q  [NUM_CH],
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FC_W-1:0]    fc,
    input  logic               rw,
    output logic [NUM_CH-1:0]  grant
);
    logic [NUM_CH-1:0] hit;
    logic              found;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign hit[i] = chan_hit(base_q[i], opt_q[i], addr, fc, rw);
    end

    // lowest index wins; reserved word blocks every channel
    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        if (is_reserved(addr)) grant = '0;
    end
endmodule

// File: rtl/cs_chan.sv
module cs_chan
    import cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              win,
    input  logic              as_n,
    input  logic [WAIT_W-1:0] ws_cfg,
    output logic              sel,
    output logic              ack
);
    localparam logic [WAIT_W-1:0] CNT_MAX = '1;
    logic [WAIT_W-1:0] cnt;
    logic [WAIT_W-1:0] ws_q;

    always_ff @(posedge clk) begin
        if (rst || as_n) begin
            sel  <= 1'b0;
            cnt  <= '0;
            ws_q <= '0;
        end else if (start) begin
            sel  <= win;
            cnt  <= '0;
            ws_q <= ws_cfg;
        end else if (sel && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ack = sel && (cnt >= ws_q);

    assert_zero_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (start && win && !as_n && ws_cfg == '0) |=> ack);
    assert_wait_delays_R4: assert property (@(posedge clk) disable iff (rst)
        (start && win && !as_n && ws_cfg != '0) |=> (sel && !ack));
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import cs_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [CH_W-1:0]   reg_ch,
    input  logic              reg_opt,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FC_W-1:0]   fc,
    input  logic              rw,
    input  logic              as_n,
    output logic [NUM_CH-1:0] cs_n,
    output logic              dtack_n
);
    base_t             base_q [NUM_CH];
    opt_t              opt_q  [NUM_CH];
    logic [NUM_CH-1:0] grant;
    logic [NUM_CH-1:0] sel;
    logic [NUM_CH-1:0] ack;
    logic              busy;
    logic              start;

    cs_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .ch(reg_ch), .sel_opt(reg_opt),
        .wdata(reg_wdata), .base_q(base_q), .opt_q(opt_q)
    );

    cs_match #(.NUM_CH(NUM_CH)) u_match (
        .base_q(base_q), .opt_q(opt_q), .addr(addr), .fc(fc), .rw(rw),
        .grant(grant)
    );

    always_ff @(posedge clk) begin
        if (rst) busy <= 1'b0;
        else     busy <= !as_n;
    end

    assign start = !as_n && !busy;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        cs_chan u_chan (
            .clk(clk), .rst(rst), .start(start), .win(grant[i]), .as_n(as_n),
            .ws_cfg(opt_q[i].ws), .sel(sel[i]), .ack(ack[i])
        );
    end

    assign cs_n    = ~sel;
    assign dtack_n = ~|ack;

    assert_single_select_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        $past(as_n) |-> (&cs_n && dtack_n));
    assert_reserved_R6: assert property (@(posedge clk) disable iff (rst)
        (start && is_reserved(addr)) |=> &cs_n);
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && !$past(as_n)) |-> $stable(cs_n));
    assert_ack_needs_select_R8: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> !(&cs_n));
endmodule

// File: tb/test_cs_decoder.sv
module test_cs_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_ch = '0;
    logic        reg_opt = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [23:0] addr = '0;
    logic [2:0]  fc = '0;
    logic        rw = 1'b1;
    logic        as_n = 1'b1;
    logic [3:0]  cs_n;
    logic        dtack_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the register contents
    logic [10:0] m_base [4];
    logic [2:0]  m_fc   [4];
    logic        m_rwq  [4];
    logic        m_en   [4];
    logic [10:0] m_mask [4];
    logic        m_cfc  [4];
    logic        m_rwc  [4];
    logic [2:0]  m_ws   [4];

    always #2.5 clk = ~clk;

    cs_decoder i_cs_decoder (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_ch(reg_ch), .reg_opt(reg_opt),
        .reg_wdata(reg_wdata), .addr(addr), .fc(fc), .rw(rw), .as_n(as_n),
        .cs_n(cs_n), .dtack_n(dtack_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_ch(input logic [23:0] a, input logic [2:0] f, input logic rd);
        if (a[23:1] == 23'h79) return -1;
        for (int i = 0; i < 4; i++) begin
            if (m_en[i] && (((a[23:13] ^ m_base[i]) & m_mask[i]) == 11'd0) &&
                (!m_cfc[i] || f == m_fc[i]) && (!m_rwc[i] || rd == m_rwq[i]))
                return i;
        end
        return -1;
    endfunction

    task automatic wr_base(input int ch, input logic [10:0] b, input logic [2:0] f,
                           input logic q, input logic e);
        @(negedge clk);
        reg_we = 1'b1; reg_ch = 2'(ch); reg_opt = 1'b0; reg_wdata = {b, f, q, e};
        @(negedge clk);
        reg_we = 1'b0;
        m_base[ch] = b; m_fc[ch] = f; m_rwq[ch] = q; m_en[ch] = e;
    endtask

    task automatic wr_opt(input int ch, input logic [10:0] mk, input logic c,
                          input logic r, input logic [2:0] w);
        @(negedge clk);
        reg_we = 1'b1; reg_ch = 2'(ch); reg_opt = 1'b1; reg_wdata = {mk, c, r, w};
        @(negedge clk);
        reg_we = 1'b0;
        m_mask[ch] = mk; m_cfc[ch] = c; m_rwc[ch] = r; m_ws[ch] = w;
    endtask

    // one bus cycle of 10 sampled clocks; req names the requirement under test
    task automatic bus_cycle(input logic [23:0] a, input logic [2:0] f, input logic rd,
                             input string req);
        int e;
        int lat;
        logic [3:0] exp_cs;
        e = exp_ch(a, f, rd);
        exp_cs = (e < 0) ? 4'hF : ~(4'b1 << e);
        lat = -1;
        @(negedge clk);
        addr = a; fc = f; rw = rd; as_n = 1'b0;
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (n == 1 || cs_n != exp_cs)
                check(cs_n == exp_cs, req, int'(cs_n), int'(exp_cs));
            if (!dtack_n && lat < 0) lat = n;
        end
        check(lat == ((e < 0) ? -1 : int'(m_ws[e]) + 1), {req, " R4 R8 ack"},
              lat, (e < 0) ? -1 : int'(m_ws[e]) + 1);
        as_n = 1'b1;
        @(negedge clk);
        check(cs_n == 4'hF && dtack_n, "R9 release", int'({cs_n, dtack_n}), 31);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_fc[i] = '0; m_rwq[i] = 1'b0; m_en[i] = 1'b0;
            m_mask[i] = '0; m_cfc[i] = 1'b0; m_rwc[i] = 1'b0; m_ws[i] = '0;
        end
        m_fc[0] = 3'b110; m_en[0] = 1'b1; m_mask[0] = '1; m_cfc[0] = 1'b1; m_ws[0] = 3'd6;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n == 4'hF && dtack_n, "R1 reset idle", int'({cs_n, dtack_n}), 31);

        // boot channel defaults
        bus_cycle(24'h000000, 3'b110, 1'b1, "R1 boot base");
        bus_cycle(24'h001FFE, 3'b110, 1'b0, "R1 boot top");
        bus_cycle(24'h002000, 3'b110, 1'b1, "R8 outside boot");
        bus_cycle(24'h000100, 3'b101, 1'b1, "R2 fc mismatch");
        bus_cycle(24'h0000F2, 3'b110, 1'b1, "R6 reserved");
        bus_cycle(24'h0000F3, 3'b110, 1'b0, "R6 reserved odd");

        // widen boot window, drop fc compare, 2 waits
        wr_opt(0, 11'b11111100000, 1'b0, 1'b0, 3'd2);
        bus_cycle(24'h03FFFE, 3'b001, 1'b1, "R3 R2 R11 wide top");
        bus_cycle(24'h040000, 3'b110, 1'b1, "R3 wide edge");
        bus_cycle(24'h0000F2, 3'b001, 1'b1, "R6 reserved wide");

        // channel 1: 64K at 0x400000, reads only, zero waits
        wr_base(1, 11'h200, 3'b101, 1'b1, 1'b1);
        wr_opt(1, 11'b11111111000, 1'b0, 1'b1, 3'd0);
        bus_cycle(24'h40FFFE, 3'b101, 1'b1, "R7 R11 read ok");
        bus_cycle(24'h40FFFE, 3'b101, 1'b0, "R7 write blocked");
        bus_cycle(24'h410000, 3'b101, 1'b1, "R3 ch1 edge");

        // channel 2 overlaps channel 0; channel 3 overlaps channel 1
        wr_base(2, 11'h000, 3'b000, 1'b0, 1'b1);
        wr_opt(2, 11'h7FF, 1'b0, 1'b0, 3'd1);
        wr_base(3, 11'h200, 3'b000, 1'b0, 1'b1);
        wr_opt(3, 11'b11111111000, 1'b0, 1'b0, 3'd3);
        bus_cycle(24'h000010, 3'b110, 1'b1, "R5 ch0 over ch2");
        bus_cycle(24'h400000, 3'b101, 1'b1, "R5 ch1 over ch3");
        bus_cycle(24'h400000, 3'b101, 1'b0, "R5 R7 ch3 on write");

        // exhaustive sweep of A23..A13
        for (int k = 0; k < 2048; k++)
            bus_cycle({k[10:0], 13'h0004}, 3'b110, k[0], "R3 R5 sweep");

        // R10: disable channel 0 mid-cycle
        @(negedge clk);
        addr = 24'h000040; fc = 3'b110; rw = 1'b1; as_n = 1'b0;
        @(negedge clk);
        check(cs_n == 4'b1110, "R10 before write", int'(cs_n), 14);
        reg_we = 1'b1; reg_ch = 2'd0; reg_opt = 1'b0; reg_wdata = {11'h000, 3'b110, 1'b0, 1'b0};
        @(negedge clk);
        reg_we = 1'b0;
        m_en[0] = 1'b0;
        for (int n = 0; n < 4; n++) begin
            check(cs_n == 4'b1110, "R10 held", int'(cs_n), 14);
            @(negedge clk);
        end
        check(!dtack_n, "R10 ack kept", int'(dtack_n), 0);
        as_n = 1'b1;
        @(negedge clk);
        bus_cycle(24'h000040, 3'b110, 1'b1, "R10 next cycle");
        bus_cycle(24'h0000F2, 3'b110, 1'b1, "R6 reserved ch2");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule